// File: doc/BRIEF.md
# SPI-to-Wishbone Command Bridge

This block lets a host processor reach a Wishbone bus through an SPI link. The host runs SPI mode 0 as master and the block acts as slave. The host drops chip select, sends a one-byte request code, a big-endian address and a big-endian byte count, and then either the write payload or dummy bytes that pull read data out. Payload bytes are packed into 32-bit words, least significant lane first. Each word becomes one classic single-cycle Wishbone access, and the address steps by one word per access.

On MISO the block returns a framed reply that lags the request by two byte slots. Two filler bytes come first. Then comes a reply code, then an echo of the address and the count, and then, for reads, the data bytes in the order they were written. SCK, chip select and MOSI are oversampled in the system clock domain, so the whole block runs on one clock.

Top module: `spiWbBridge`

## Requirements
- R1: Bytes are framed in SPI mode 0 while csN is low. MOSI is taken most significant bit first on SCK rising edges, and MISO changes only after SCK falling edges. The system clock runs at least 8 times faster than SCK.
- R2: A request is code 0xA2 (write) or 0xA1 (read). The code is followed by a 4-byte address and then a 2-byte length, both most significant byte first.
- R3: Reply byte positions, counted from 0 at the start of a transaction: positions 0 and 1 carry the filler 0xFF. Position 2 carries 0xA3 for a read or 0xA4 for a write. Positions 3 to 6 echo the address, most significant byte first, and positions 7 and 8 echo the length, most significant byte first.
- R4: Write payload bytes are packed so that the first byte of each group of four lands in bits 7:0 and the fourth lands in bits 31:24. Each complete group starts exactly one write access. Bytes beyond the length are ignored, and a trailing group of fewer than four bytes is never written.
- R5: For a read, ceil(length/4) words are fetched. From position 9 on, exactly length data bytes are returned, bits 7:0 of each word first. A length of 0 causes no bus access.
- R6: Each access raises wbCyc and wbStb together with wbSel = 4'hF, and sets wbWe only for writes. Address, data and wbWe stay stable until wbAck, and the cycle ends in the clock after wbAck.
- R7: Each access after the first in a transaction uses an address 4 above the previous one.
- R8: A first byte other than 0xA1 or 0xA2 causes no bus access, and MISO carries 0xFF for the whole transaction.
- R9: Raising csN discards a partial request without any bus access, and the next transaction is parsed from its first byte. An access already in progress still runs to its wbAck.
- R10: MISO is 1 while csN is high. Every reply position beyond the frame carries 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock from the host |
| csN | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial reply to the host |
| wbAdr | output | 32 | Wishbone byte address |
| wbDatO | output | 32 | Wishbone write data |
| wbDatI | input | 32 | Wishbone read data |
| wbSel | output | 4 | Wishbone byte lane selects |
| wbWe | output | 1 | Wishbone write enable |
| wbCyc | output | 1 | Wishbone cycle |
| wbStb | output | 1 | Wishbone strobe |
| wbAck | input | 1 | Wishbone acknowledge |

## Verification
The case where two functions coincide is chip select rising, which resets the SPI framing and the parser, while a Wishbone write that the same transaction started is still waiting for its acknowledge. The bench provokes it by stretching the slave's acknowledge to 60 clocks on a write whose last payload byte ends just before csN rises. It judges the result by three things: wbCyc is still high at the moment csN rises, the word later appears in the slave memory with its packed value, and the next read returns a clean, correctly framed reply.

// File: rtl/spiWbPkg.sv
package spiWbPkg;

  localparam logic [7:0] OP_RD_REQ = 8'hA1;
  localparam logic [7:0] OP_WR_REQ = 8'hA2;
  localparam logic [7:0] OP_RD_RSP = 8'hA3;
  localparam logic [7:0] OP_WR_RSP = 8'hA4;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_READ,
    CMD_WRITE
  } cmdKindT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_LEN,
    ST_LAUNCH,
    ST_WDATA,
    ST_RDATA,
    ST_DONE
  } ctrlStateT;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic cmdLoad;
    logic addrShift;
    logic lenShift;
    logic wordShift;
    logic busStart;
    logic busWrite;
  } ctrlStrobeT;

  function automatic cmdKindT decodeCmd(input logic [7:0] code);
    if (code == OP_RD_REQ) return CMD_READ;
    if (code == OP_WR_REQ) return CMD_WRITE;
    return CMD_NONE;
  endfunction

endpackage

// File: rtl/spiWbSync.sv
module spiWbSync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= {STAGES{RST_VAL}};
    else       pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/spiWbCtrl.sv
module spiWbCtrl
  import spiWbPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csIdle,
  input  logic             rxValid,
  input  logic [7:0]       rxByte,
  input  logic [LEN_W-1:0] hdrLen,
  input  logic             rdWant,
  output ctrlStrobeT       strobe
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int LEN_BYTES  = LEN_W / 8;
  localparam int LANES      = DATA_W / 8;
  localparam int LANE_W     = $clog2(LANES);
  localparam int HC_W       = $clog2(ADDR_BYTES + LEN_BYTES) + 1;

  ctrlStateT        state, stateNext;
  cmdKindT          kind, kindNext;
  logic [HC_W-1:0]  hdrCnt, hdrCntNext;
  logic [LEN_W-1:0] payCnt, payCntNext;

  always_comb begin
    strobe     = '0;
    stateNext  = state;
    kindNext   = kind;
    hdrCntNext = hdrCnt;
    payCntNext = payCnt;
    case (state)
      ST_IDLE: if (rxValid) begin
        strobe.cmdLoad = 1'b1;
        kindNext       = decodeCmd(rxByte);
        hdrCntNext     = '0;
        stateNext      = (decodeCmd(rxByte) == CMD_NONE) ? ST_DONE : ST_ADDR;
      end
      ST_ADDR: if (rxValid) begin
        strobe.addrShift = 1'b1;
        if (hdrCnt == HC_W'(ADDR_BYTES - 1)) begin
          hdrCntNext = '0;
          stateNext  = ST_LEN;
        end else begin
          hdrCntNext = hdrCnt + 1'b1;
        end
      end
      ST_LEN: if (rxValid) begin
        strobe.lenShift = 1'b1;
        if (hdrCnt == HC_W'(LEN_BYTES - 1)) stateNext = ST_LAUNCH;
        else hdrCntNext = hdrCnt + 1'b1;
      end
      ST_LAUNCH: begin
        payCntNext = '0;
        if (hdrLen == '0) begin
          stateNext = ST_DONE;
        end else if (kind == CMD_WRITE) begin
          stateNext = ST_WDATA;
        end else begin
          strobe.busStart = 1'b1;   // first read word, ready before data slots
          stateNext       = ST_RDATA;
        end
      end
      ST_WDATA: if (rxValid) begin
        strobe.wordShift = 1'b1;
        if (&payCnt[LANE_W-1:0]) begin
          strobe.busStart = 1'b1;
          strobe.busWrite = 1'b1;
        end
        payCntNext = payCnt + 1'b1;
        if (payCnt == hdrLen - 1'b1) stateNext = ST_DONE;
      end
      ST_RDATA: if (rdWant) strobe.busStart = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      kind   <= CMD_NONE;
      hdrCnt <= '0;
      payCnt <= '0;
    end else if (csIdle) begin
      state  <= ST_IDLE;
      kind   <= CMD_NONE;
      hdrCnt <= '0;
      payCnt <= '0;
    end else begin
      state  <= stateNext;
      kind   <= kindNext;
      hdrCnt <= hdrCntNext;
      payCnt <= payCntNext;
    end
  end
endmodule

// File: rtl/spiWbDatapath.sv
module spiWbDatapath
  import spiWbPkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 32,
  parameter int          LEN_W       = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  FILL        = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sck,
  input  logic              csN,
  input  logic              mosi,
  output logic              miso,
  input  ctrlStrobeT        strobe,
  output logic              csIdle,
  output logic              rxValid,
  output logic [7:0]        rxByte,
  output logic [LEN_W-1:0]  hdrLen,
  output logic              rdWant,
  output logic [ADDR_W-1:0] wbAdr,
  output logic [DATA_W-1:0] wbDatO,
  input  logic [DATA_W-1:0] wbDatI,
  output logic [DATA_W/8-1:0] wbSel,
  output logic              wbWe,
  output logic              wbCyc,
  output logic              wbStb,
  input  logic              wbAck
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int LEN_BYTES  = LEN_W / 8;
  localparam int LANES      = DATA_W / 8;
  localparam int LANE_W     = $clog2(LANES);
  localparam int POS_W      = LEN_W + 2;
  localparam logic [POS_W-1:0] POS_OP   = POS_W'(2);
  localparam logic [POS_W-1:0] POS_HDR  = POS_W'(3);
  localparam logic [POS_W-1:0] POS_DATA = POS_W'(3 + ADDR_BYTES + LEN_BYTES);
  localparam logic [POS_W-1:0] POS_MAX  = '1;
  localparam logic [ADDR_W-1:0] ADR_STEP = ADDR_W'(LANES);
  localparam logic [2:0] SYNC_RST = 3'b010;  // {sck, csN, mosi}

  // ---------------- input synchronisers ----------------
  logic [2:0] rawIn, syncOut;
  logic sckS, csS, mosiS, sckPrev;
  assign rawIn = {sck, csN, mosi};

  for (genvar g = 0; g < 3; g++) begin : gSync
    spiWbSync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST[g])) uSync (
      .clk (clk),
      .rstN(rstN),
      .din (rawIn[g]),
      .dout(syncOut[g])
    );
  end
  assign {sckS, csS, mosiS} = syncOut;
  assign csIdle = csS;

  logic sckRise, sckFall;
  assign sckRise = sckS & ~sckPrev & ~csS;
  assign sckFall = ~sckS & sckPrev & ~csS;

  // ---------------- serial shifters ----------------
  logic [2:0]       bitCnt;
  logic [7:0]       rxShift, txShift, txNext;
  logic [15:0]      rxHist;      // last two received bytes, older in upper half
  logic             loadPend;
  logic [POS_W-1:0] posCnt;      // completed byte slots in this transaction
  cmdKindT          cmdKind;

  assign rxByte = rxShift;
  assign miso   = txShift[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev  <= 1'b0;
      bitCnt   <= '0;
      rxShift  <= '0;
      rxValid  <= 1'b0;
      rxHist   <= '0;
      txShift  <= FILL;
      loadPend <= 1'b0;
      posCnt   <= '0;
    end else begin
      sckPrev <= sckS;
      if (csS) begin
        bitCnt   <= '0;
        rxValid  <= 1'b0;
        txShift  <= FILL;
        loadPend <= 1'b0;
        posCnt   <= '0;
      end else begin
        rxValid <= 1'b0;
        if (sckRise) begin
          rxShift <= {rxShift[6:0], mosiS};
          bitCnt  <= bitCnt + 1'b1;
          if (bitCnt == 3'd7) begin
            rxValid  <= 1'b1;
            loadPend <= 1'b1;
            if (posCnt != POS_MAX) posCnt <= posCnt + 1'b1;
          end
        end
        if (rxValid) rxHist <= {rxHist[7:0], rxShift};
        if (sckFall) begin
          if (loadPend) begin
            txShift  <= txNext;
            loadPend <= 1'b0;
          end else begin
            txShift <= {txShift[6:0], 1'b1};
          end
        end
      end
    end
  end

  // ---------------- header registers ----------------
  logic [ADDR_W-1:0] hdrAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdKind <= CMD_NONE;
      hdrAddr <= '0;
      hdrLen  <= '0;
    end else begin
      if (csS) cmdKind <= CMD_NONE;
      else if (strobe.cmdLoad) cmdKind <= decodeCmd(rxShift);
      if (strobe.addrShift) hdrAddr <= {hdrAddr[ADDR_W-9:0], rxShift};
      if (strobe.lenShift)  hdrLen  <= {hdrLen[LEN_W-9:0], rxShift};
    end
  end

  // ---------------- reply byte selection ----------------
  logic [DATA_W-1:0] rdBuf;
  logic [POS_W-1:0]  dataIdx, dataNext, lenExt;
  logic              inData;

  always_comb begin
    dataIdx  = posCnt - POS_DATA;
    dataNext = dataIdx + 1'b1;
    lenExt   = {2'b00, hdrLen};
    inData   = (cmdKind == CMD_READ) && (posCnt >= POS_DATA) && (dataIdx < lenExt);
    txNext   = FILL;
    if (cmdKind != CMD_NONE) begin
      if (posCnt == POS_OP)
        txNext = (cmdKind == CMD_READ) ? OP_RD_RSP : OP_WR_RSP;
      else if (posCnt >= POS_HDR && posCnt < POS_DATA)
        txNext = rxHist[15:8];     // header echo trails reception by two slots
      else if (inData)
        txNext = 8'(rdBuf >> {dataIdx[LANE_W-1:0], 3'b000});
    end
    rdWant = sckFall && loadPend && inData && (&dataIdx[LANE_W-1:0]) && (dataNext < lenExt);
  end

  // ---------------- Wishbone master ----------------
  logic [DATA_W-1:0] wrBuf, wrWord;
  assign wrWord = {rxShift, wrBuf[DATA_W-1:8]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrBuf  <= '0;
      wbDatO <= '0;
      rdBuf  <= '0;
      wbAdr  <= '0;
      wbCyc  <= 1'b0;
      wbWe   <= 1'b0;
    end else begin
      if (strobe.wordShift) wrBuf <= wrWord;
      if (strobe.lenShift)  wbAdr <= hdrAddr;
      if (strobe.busStart) begin
        wbCyc <= 1'b1;
        wbWe  <= strobe.busWrite;
        if (strobe.busWrite) wbDatO <= wrWord;
      end else if (wbCyc && wbAck) begin
        wbCyc <= 1'b0;
        wbAdr <= wbAdr + ADR_STEP;
        if (!wbWe) rdBuf <= wbDatI;
      end
    end
  end

  assign wbStb = wbCyc;
  assign wbSel = wbCyc ? '1 : '0;
endmodule

// File: rtl/spiWbBridge.sv
module spiWbBridge
  import spiWbPkg::*;
#(
  parameter int         ADDR_W      = 32,
  parameter int         DATA_W      = 32,
  parameter int         LEN_W       = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] FILL        = 8'hFF
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sck,
  input  logic                csN,
  input  logic                mosi,
  output logic                miso,
  output logic [ADDR_W-1:0]   wbAdr,
  output logic [DATA_W-1:0]   wbDatO,
  input  logic [DATA_W-1:0]   wbDatI,
  output logic [DATA_W/8-1:0] wbSel,
  output logic                wbWe,
  output logic                wbCyc,
  output logic                wbStb,
  input  logic                wbAck
);
  ctrlStrobeT       strobe;
  logic             csIdle, rxValid, rdWant;
  logic [7:0]       rxByte;
  logic [LEN_W-1:0] hdrLen;

  spiWbCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .csIdle(csIdle), .rxValid(rxValid),
    .rxByte(rxByte), .hdrLen(hdrLen), .rdWant(rdWant), .strobe(strobe)
  );

  spiWbDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
    .SYNC_STAGES(SYNC_STAGES), .FILL(FILL)
  ) uData (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .mosi(mosi), .miso(miso),
    .strobe(strobe), .csIdle(csIdle), .rxValid(rxValid), .rxByte(rxByte),
    .hdrLen(hdrLen), .rdWant(rdWant),
    .wbAdr(wbAdr), .wbDatO(wbDatO), .wbDatI(wbDatI), .wbSel(wbSel),
    .wbWe(wbWe), .wbCyc(wbCyc), .wbStb(wbStb), .wbAck(wbAck)
  );
endmodule

// File: rtl/spiWbBridgeChecker.sv
module spiWbBridgeChecker #(
  parameter int         ADDR_W = 32,
  parameter int         DATA_W = 32,
  parameter logic [7:0] FILL   = 8'hFF
) (
  input logic                clk,
  input logic                rstN,
  input logic                csN,
  input logic                miso,
  input logic [ADDR_W-1:0]   wbAdr,
  input logic [DATA_W-1:0]   wbDatO,
  input logic [DATA_W/8-1:0] wbSel,
  input logic                wbWe,
  input logic                wbCyc,
  input logic                wbStb,
  input logic                wbAck
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  AST_CYC_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    wbCyc && !wbAck |=> wbCyc);  // R6
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    wbCyc && !wbAck |=> $stable(wbAdr) && $stable(wbWe) && $stable(wbDatO));  // R6
  AST_STB_SEL_FULL: assert property (@(posedge clk) disable iff (!rstN)
    wbCyc |-> wbStb && (wbSel == '1));  // R6
  AST_CYC_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    wbCyc && wbAck |=> !wbCyc);  // R6
  AST_ADR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    wbCyc && wbAck |=> wbAdr == $past(wbAdr) + STEP);  // R7
  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    csN && $past(csN) && $past(csN, 2) && $past(csN, 3) |-> miso == FILL[7]);  // R10
endmodule

bind spiWbBridge spiWbBridgeChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FILL(FILL)) uChk (
  .clk(clk), .rstN(rstN), .csN(csN), .miso(miso), .wbAdr(wbAdr), .wbDatO(wbDatO),
  .wbSel(wbSel), .wbWe(wbWe), .wbCyc(wbCyc), .wbStb(wbStb), .wbAck(wbAck)
);

// File: tb/spiWbBridge_test.sv
module spiWbBridge_test;
  localparam int HALF = 8;  // SCK half period in system clocks

  logic clk = 1'b0, rstN = 1'b0, sck = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic miso, wbWe, wbCyc, wbStb;
  logic wbAck = 1'b0;
  logic [31:0] wbAdr, wbDatO;
  logic [31:0] wbDatI = '0;
  logic [3:0] wbSel;

  always #10 clk = ~clk;

  spiWbBridge uut (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .mosi(mosi), .miso(miso),
    .wbAdr(wbAdr), .wbDatO(wbDatO), .wbDatI(wbDatI), .wbSel(wbSel),
    .wbWe(wbWe), .wbCyc(wbCyc), .wbStb(wbStb), .wbAck(wbAck)
  );

  int checks = 0, fails = 0, wrCount = 0, rdCount = 0;
  int slvWait = 0, forceWait = 0;
  bit finished = 0;
  logic [31:0] mem[16];
  logic [31:0] model[16];
  logic [31:0] lastWrAdr = '0;
  logic [7:0] txq[64];
  logic [7:0] rxq[64];
  logic cycAtCsRise;

  // Wishbone slave, driven away from the active edge
  always @(negedge clk) begin
    if (wbCyc && !wbAck) begin
      if (slvWait == 0) begin
        wbAck <= 1'b1;
        if (wbWe) begin
          mem[wbAdr[5:2]] = wbDatO;
          lastWrAdr = wbAdr;
          wrCount++;
        end else begin
          wbDatI <= mem[wbAdr[5:2]];
          rdCount++;
        end
        slvWait = (forceWait != 0) ? forceWait : int'($urandom % 4);
      end else begin
        slvWait--;
      end
    end else if (wbAck) begin
      wbAck <= 1'b0;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expByte(int p, logic [7:0] cmd, logic [31:0] a, int len);
    int k;
    logic [31:0] w;
    if (cmd != 8'hA1 && cmd != 8'hA2) return 8'hFF;
    if (p < 2) return 8'hFF;
    if (p == 2) return cmd + 8'd2;
    if (p <= 6) return a[8*(6-p) +: 8];
    if (p == 7) return 8'(len >> 8);
    if (p == 8) return 8'(len);
    if (cmd == 8'hA1 && p - 9 < len) begin
      k = p - 9;
      w = model[(int'(a[5:2]) + k / 4) % 16];
      return w[8*(k%4) +: 8];
    end
    return 8'hFF;
  endfunction

  task automatic spiByte(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      repeat (HALF) @(negedge clk);
      rx[b] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic runXfer(input int n);
    logic [7:0] r;
    @(negedge clk);
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      spiByte(txq[i], r);
      rxq[i] = r;
    end
    repeat (HALF) @(negedge clk);
    cycAtCsRise = wbCyc;
    csN = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic doTxn(input string tag, input logic [7:0] cmd, input logic [31:0] a,
                       input int len, input int extra, input int settle);
    int n, wr0, rd0, bad;
    logic [7:0] expq[64];
    logic [7:0] actB, expB;
    n = 7 + len + extra;
    txq[0] = cmd;
    for (int i = 0; i < 4; i++) txq[1+i] = a[8*(3-i) +: 8];
    txq[5] = 8'(len >> 8);
    txq[6] = 8'(len);
    for (int i = 7; i < n; i++) txq[i] = 8'($urandom);
    for (int p = 0; p < n; p++) expq[p] = expByte(p, cmd, a, len);
    wr0 = wrCount;
    rd0 = rdCount;
    runXfer(n);
    repeat (settle) @(negedge clk);
    bad = 0;
    actB = 8'h00;
    expB = 8'h00;
    for (int p = 0; p < n; p++)
      if (bad == 0 && rxq[p] !== expq[p]) begin
        bad = 1;
        actB = rxq[p];
        expB = expq[p];
      end
    chk(tag, "reply byte", {24'd0, actB}, {24'd0, expB});
    if (cmd == 8'hA2)
      for (int i = 0; i < len / 4; i++)
        model[(int'(a[5:2]) + i) % 16] = {txq[10+4*i], txq[9+4*i], txq[8+4*i], txq[7+4*i]};
    chk(tag, "write accesses", wrCount - wr0, (cmd == 8'hA2) ? len / 4 : 0);
    chk(tag, "read accesses", rdCount - rd0, (cmd == 8'hA1) ? (len + 3) / 4 : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    int len;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 16; i++) begin
      mem[i] = 32'h0;
      model[i] = 32'h0;
    end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10", "miso at reset", {31'd0, miso}, 32'd1);
    chk("R6", "cyc at reset", {31'd0, wbCyc}, 32'd0);

    // R2 R3 R4: directed write of 11 22 33 44
    txq[0] = 8'hA2; txq[1] = 8'h00; txq[2] = 8'h00; txq[3] = 8'h01; txq[4] = 8'h10;
    txq[5] = 8'h00; txq[6] = 8'h04;
    txq[7] = 8'h11; txq[8] = 8'h22; txq[9] = 8'h33; txq[10] = 8'h44; txq[11] = 8'h00;
    runXfer(12);
    chk("R4", "packed word", mem[4], 32'h44332211);
    chk("R2", "write address", lastWrAdr, 32'h0000_0110);
    chk("R3", "reply code", {24'd0, rxq[2]}, 32'hA4);
    chk("R3", "address echo", {rxq[3], rxq[4], rxq[5], rxq[6]}, 32'h0000_0110);
    chk("R10", "trailing filler", {24'd0, rxq[11]}, 32'hFF);
    model[4] = 32'h44332211;

    // R5 read back, bytes in written order
    doTxn("R5", 8'hA1, 32'h0000_0110, 4, 1, 0);
    chk("R5", "first data byte", {24'd0, rxq[9]}, 32'h11);

    // R4 multi-word write, R7 address step, then read
    doTxn("R7", 8'hA2, 32'h0000_0120, 12, 0, 0);
    chk("R7", "last write address", lastWrAdr, 32'h0000_0128);
    doTxn("R7", 8'hA1, 32'h0000_0120, 12, 2, 0);

    // R4 partial trailing group and bytes beyond length
    doTxn("R4", 8'hA2, 32'h0000_0130, 6, 0, 0);
    doTxn("R4", 8'hA2, 32'h0000_0138, 4, 4, 0);
    doTxn("R4", 8'hA1, 32'h0000_0130, 16, 0, 0);

    // R5 length zero and non-multiple read
    doTxn("R5", 8'hA1, 32'h0000_0100, 0, 3, 0);
    doTxn("R5", 8'hA1, 32'h0000_0104, 5, 2, 0);

    // R8 unknown request code
    doTxn("R8", 8'h55, 32'h0000_0100, 4, 2, 0);

    // R9 abort inside header
    begin
      int wr0;
      wr0 = wrCount;
      txq[0] = 8'hA2; txq[1] = 8'h00; txq[2] = 8'h00;
      runXfer(3);
      chk("R9", "no access after abort", wrCount - wr0, 0);
      doTxn("R9", 8'hA1, 32'h0000_0110, 4, 0, 0);
    end

    // R9 chip select rises while a write waits for ACK
    slvWait = 60;
    forceWait = 60;
    doTxn("R9", 8'hA2, 32'h0000_011C, 4, 0, 100);
    chk("R9", "cycle open at cs rise", {31'd0, cycAtCsRise}, 32'd1);
    forceWait = 0;
    slvWait = 0;
    chk("R9", "late write landed", mem[7], model[7]);
    doTxn("R9", 8'hA1, 32'h0000_011C, 4, 0, 0);

    // R1 R3 R5 R7 constrained random mix
    for (int it = 0; it < 14; it++) begin
      a = 32'h100 + 32'(4 * ($urandom % 12));
      if ($urandom % 2 == 0) begin
        len = 4 * int'(1 + $urandom % 4);
        doTxn("R1", 8'hA2, a, len, int'($urandom % 3), 0);
      end else begin
        len = int'($urandom % 14);
        doTxn("R3", 8'hA1, a, len, int'($urandom % 3), 0);
      end
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule